// File: doc/BRIEF.md
# Program ROM Fetch Address Decoder

This block connects a 16-bit byte-addressed instruction fetch port to a small on-chip program ROM of 256 sixteen-bit words. On every rising clock edge it samples the fetch address. It drops the alignment bit to form a word index and checks the upper address bits against the page where the ROM is placed. One cycle later it presents either the stored instruction or, when the page check fails, a configurable no-operation word together with a bus-error flag.

The ROM page is placed by a parameter. It can sit at the top of the space, covering a reset vector of 0xFFFE, or at the bottom, covering a reset vector of 0x0000. An optional aliasing mode makes a chosen set of upper address bits don't-care, so the same page answers at several places in the space. The ROM image is computed inside the block from a key parameter, so no external file is needed. The memory is written so that an FPGA block RAM can be inferred.

Top module: `fetch_rom_decoder`

## Requirements
- R1: A synchronous active-high reset clears `instr` to 0 and clears both `misaligned` and `bus_err`. These values appear after the first clock edge at which `rst` is high.
- R2: Read latency is one clock. The address present at a rising edge decides the outputs from just after that edge until the next edge. The word index is `fetch_addr[8:1]`.
- R3: ROM word i (0..255) holds `{i[7:0], i[7:0]} ^ ROM_KEY`, with `ROM_KEY` defaulting to 16'h5A3C. Bit b equals index bit (b mod 8) XOR key bit b.
- R4: With `PAGE_AT_TOP`=1 the ROM answers on 0xFE00–0xFFFF, and a fetch at the reset vector 0xFFFE returns word 255.
- R5: With `PAGE_AT_TOP`=0 the ROM answers on 0x0000–0x01FF, and a fetch at the reset vector 0x0000 returns word 0.
- R6: When the page check fails, `instr` equals `NOP_WORD` (default 16'h7F00) and `bus_err` is 1 for that fetch. ROM data is never presented.
- R7: A fetch address with bit 0 set raises `misaligned` for that fetch. The word still comes from index `fetch_addr[8:1]`, and the page check is unaffected.
- R8: With aliasing off, a difference in any of `fetch_addr[15:9]` from the page value is a miss.
- R9: With aliasing on, address bit 9+k is ignored by the page check wherever `ALIAS_MASK[k]` is 1. The other upper bits must still match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fetch_addr | input | 16 | Byte address of the instruction fetch |
| instr | output | 16 | Registered instruction word, or NOP on a miss |
| misaligned | output | 1 | Registered flag: the fetch address was odd |
| bus_err | output | 1 | Registered flag: the fetch address was outside the ROM page |

## Verification
The bench builds two copies of the block side by side, and both are driven by the same addresses. The default copy has the page at the top and aliasing off. This makes the 0xFFFE reset vector, a sweep of the top page, and strict misses on every upper-bit difference reachable. The second copy has the page at the bottom and aliasing on for address bits 15 and 14. This makes the 0x0000 reset vector reachable, along with hits at mirror addresses such as 0x4000 and 0xC1FE and a miss when an unmasked bit such as bit 13 differs. Seeded random addresses are checked against a bench model of both configurations.

// File: rtl/fetch_rom_pkg.sv
package fetch_rom_pkg;

  // Per-fetch status that travels alongside the read data.
  typedef struct packed {
    logic misaligned;
    logic page_miss;
  } fetch_flags_t;

  // Image generator: bit b = index bit (b mod idx_w) xor key bit b.
  function automatic logic [63:0] rom_pattern(input int unsigned idx,
                                              input int unsigned idx_w,
                                              input logic [63:0] key);
    logic [63:0] v;
    v = '0;
    for (int b = 0; b < 64; b++) begin
      v[b] = idx[b % idx_w] ^ key[b];
    end
    return v;
  endfunction

endpackage

// File: rtl/frd_addr_split.sv
module frd_addr_split #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 8,
  localparam int UP_W  = ADDR_W - IDX_W - 1
) (
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic [IDX_W-1:0]  word_idx,
  output logic [UP_W-1:0]   upper_bits,
  output logic              odd_byte
);

  // Byte address -> word index by dropping bit 0.
  assign odd_byte   = fetch_addr[0];
  assign word_idx   = fetch_addr[IDX_W:1];
  assign upper_bits = fetch_addr[ADDR_W-1:IDX_W+1];

endmodule

// File: rtl/frd_page_match.sv
module frd_page_match #(
  parameter int              UP_W        = 7,
  parameter bit              PAGE_AT_TOP = 1'b1,
  parameter bit              ALIAS_EN    = 1'b0,
  parameter logic [UP_W-1:0] ALIAS_MASK  = '0
) (
  input  logic [UP_W-1:0] upper_bits,
  output logic            page_hit
);

  // Bits that take part in the compare.
  localparam logic [UP_W-1:0] CARE = ALIAS_EN ? ~ALIAS_MASK : {UP_W{1'b1}};

  generate
    if (PAGE_AT_TOP) begin : g_top
      // Top page: every cared bit must be one.
      assign page_hit = &(upper_bits | ~CARE);
    end else begin : g_bottom
      // Bottom page: every cared bit must be zero.
      assign page_hit = ~|(upper_bits & CARE);
    end
  endgenerate

endmodule

// File: rtl/frd_rom_array.sv
module frd_rom_array
  import fetch_rom_pkg::*;
#(
  parameter int          DEPTH   = 256,
  parameter int          DATA_W  = 16,
  parameter logic [63:0] ROM_KEY = 64'h5A3C,
  localparam int         IDX_W   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Computed image; synthesis folds this into the RAM initial contents.
  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      logic [63:0] pat;
      pat    = rom_pattern(i, IDX_W, ROM_KEY);
      mem[i] = pat[DATA_W-1:0];
    end
  end

  // Synchronous read with a resettable output register.
  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= mem[rd_idx];
  end

endmodule

// File: rtl/fetch_rom_decoder.sv
module fetch_rom_decoder
  import fetch_rom_pkg::*;
#(
  parameter int                                   ADDR_W      = 16,
  parameter int                                   DATA_W      = 16,
  parameter int                                   ROM_WORDS   = 256,
  parameter bit                                   PAGE_AT_TOP = 1'b1,
  parameter bit                                   ALIAS_EN    = 1'b0,
  parameter logic [ADDR_W-$clog2(ROM_WORDS)-2:0]  ALIAS_MASK  = '0,
  parameter logic [DATA_W-1:0]                    NOP_WORD    = 16'h7F00,
  parameter logic [63:0]                          ROM_KEY     = 64'h5A3C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic [DATA_W-1:0] instr,
  output logic              misaligned,
  output logic              bus_err
);

  localparam int IDX_W = $clog2(ROM_WORDS);
  localparam int UP_W  = ADDR_W - IDX_W - 1;

  logic [IDX_W-1:0]  word_idx;
  logic [UP_W-1:0]   upper_bits;
  logic              odd_byte;
  logic              page_hit;
  logic [DATA_W-1:0] rom_q;
  fetch_flags_t      flags_q;

  frd_addr_split #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
  ) u_split (
    .fetch_addr (fetch_addr),
    .word_idx   (word_idx),
    .upper_bits (upper_bits),
    .odd_byte   (odd_byte)
  );

  frd_page_match #(
    .UP_W        (UP_W),
    .PAGE_AT_TOP (PAGE_AT_TOP),
    .ALIAS_EN    (ALIAS_EN),
    .ALIAS_MASK  (ALIAS_MASK)
  ) u_match (
    .upper_bits (upper_bits),
    .page_hit   (page_hit)
  );

  frd_rom_array #(
    .DEPTH   (ROM_WORDS),
    .DATA_W  (DATA_W),
    .ROM_KEY (ROM_KEY)
  ) u_rom (
    .clk     (clk),
    .rst     (rst),
    .rd_idx  (word_idx),
    .rd_data (rom_q)
  );

  // Flags registered in the same edge as the ROM read.
  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else begin
      flags_q.misaligned <= odd_byte;
      flags_q.page_miss  <= ~page_hit;
    end
  end

  assign instr      = flags_q.page_miss ? NOP_WORD : rom_q;
  assign misaligned = flags_q.misaligned;
  assign bus_err    = flags_q.page_miss;

endmodule

// File: rtl/fetch_rom_decoder_chk.sv
module fetch_rom_decoder_chk
  import fetch_rom_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter int                DATA_W      = 16,
  parameter int                ROM_WORDS   = 256,
  parameter bit                PAGE_AT_TOP = 1'b1,
  parameter bit                ALIAS_EN    = 1'b0,
  parameter logic [ADDR_W-$clog2(ROM_WORDS)-2:0] ALIAS_MASK = '0,
  parameter logic [DATA_W-1:0] NOP_WORD    = 16'h7F00,
  parameter logic [63:0]       ROM_KEY     = 64'h5A3C
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic [DATA_W-1:0] instr,
  input logic              misaligned,
  input logic              bus_err
);

  localparam int IDX_W = $clog2(ROM_WORDS);
  localparam int UP_W  = ADDR_W - IDX_W - 1;

  logic [ADDR_W-1:0] addr_d;
  logic [UP_W-1:0]   ign;
  logic [UP_W-1:0]   up_d;
  logic              miss_exp;
  logic [63:0]       pat_exp;

  always_ff @(posedge clk) addr_d <= fetch_addr;

  assign ign  = ALIAS_EN ? ALIAS_MASK : '0;
  assign up_d = addr_d[ADDR_W-1:IDX_W+1];

  always_comb begin
    miss_exp = 1'b0;
    for (int k = 0; k < UP_W; k++) begin
      if (!ign[k] && (up_d[k] != PAGE_AT_TOP)) miss_exp = 1'b1;
    end
    pat_exp = rom_pattern(32'(addr_d[IDX_W:1]), IDX_W, ROM_KEY);
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (instr == '0 && !misaligned && !bus_err)); // R1

  AST_MISALIGN_FLAG: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (misaligned == addr_d[0])); // R7

  AST_MISS_NOP: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> (instr == NOP_WORD)); // R6

  AST_PAGE_DECODE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (bus_err == miss_exp)); // R9

  AST_HIT_DATA: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !bus_err) |-> (instr == pat_exp[DATA_W-1:0])); // R3

endmodule

bind fetch_rom_decoder fetch_rom_decoder_chk #(
  .ADDR_W      (ADDR_W),
  .DATA_W      (DATA_W),
  .ROM_WORDS   (ROM_WORDS),
  .PAGE_AT_TOP (PAGE_AT_TOP),
  .ALIAS_EN    (ALIAS_EN),
  .ALIAS_MASK  (ALIAS_MASK),
  .NOP_WORD    (NOP_WORD),
  .ROM_KEY     (ROM_KEY)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .fetch_addr (fetch_addr),
  .instr      (instr),
  .misaligned (misaligned),
  .bus_err    (bus_err)
);

// File: tb/test_fetch_rom_decoder.sv
module test_fetch_rom_decoder;

  localparam logic [15:0] KEY = 16'h5A3C;
  localparam logic [15:0] NOP = 16'h7F00;
  localparam logic [6:0]  AMASK = 7'b1100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] fetch_addr = 16'hFFFE;
  logic [15:0] instr_a, instr_b;
  logic        mis_a, mis_b, be_a, be_b;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  // Default build: page at top, aliasing off.
  fetch_rom_decoder i_fetch_rom_decoder (
    .clk (clk), .rst (rst), .fetch_addr (fetch_addr),
    .instr (instr_a), .misaligned (mis_a), .bus_err (be_a)
  );

  // Second build: page at bottom, address bits 15 and 14 aliased.
  fetch_rom_decoder #(
    .PAGE_AT_TOP (1'b0), .ALIAS_EN (1'b1), .ALIAS_MASK (AMASK)
  ) i_fetch_rom_decoder_alias (
    .clk (clk), .rst (rst), .fetch_addr (fetch_addr),
    .instr (instr_b), .misaligned (mis_b), .bus_err (be_b)
  );

  function automatic logic [15:0] exp_word(input logic [15:0] a);
    logic [7:0] i;
    i = a[8:1];
    return {i, i} ^ KEY;
  endfunction

  function automatic logic exp_miss(input logic [15:0] a, input logic top,
                                    input logic [6:0] ignore);
    logic [6:0] want;
    want = top ? 7'h7F : 7'h00;
    return ((a[15:9] ^ want) & ~ignore) != 7'h00;
  endfunction

  task automatic check(input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Compare both builds against the model for address a.
  task automatic check_all(input string tag, input logic [15:0] a);
    logic ma, mb;
    ma = exp_miss(a, 1'b1, 7'h00);
    mb = exp_miss(a, 1'b0, AMASK);
    check({tag, " top instr"},   instr_a, ma ? NOP : exp_word(a));
    check({tag, " top berr"},    {15'd0, be_a}, {15'd0, ma});
    check({tag, " top mis"},     {15'd0, mis_a}, {15'd0, a[0]});
    check({tag, " alias instr"}, instr_b, mb ? NOP : exp_word(a));
    check({tag, " alias berr"},  {15'd0, be_b}, {15'd0, mb});
    check({tag, " alias mis"},   {15'd0, mis_b}, {15'd0, a[0]});
  endtask

  task automatic fetch(input string tag, input logic [15:0] a);
    fetch_addr = a;
    @(negedge clk);
    check_all(tag, a);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1357_9BDF));
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 reset instr", instr_a, 16'h0000);
    check("R1 reset flags", {14'd0, mis_a, be_a}, 16'h0000);
    check("R1 reset alias", {instr_b ^ 16'h0, 16'h0} [31:16], 16'h0000);
    rst = 1'b0;

    // R4: top reset vector; R5: bottom reset vector; R6: misses
    fetch("R4 vec FFFE", 16'hFFFE);
    check("R4 word255", instr_a, {8'hFF, 8'hFF} ^ KEY);
    fetch("R5 vec 0000", 16'h0000);
    check("R5 word0", instr_b, KEY);
    check("R6 top miss berr", {15'd0, be_a}, 16'h0001);
    check("R6 top miss nop", instr_a, NOP);

    // R2, R3: sweep of every aligned word in both pages
    for (int i = 0; i < 256; i++) fetch("R3 top sweep", 16'hFE00 + 16'(2 * i));
    for (int i = 0; i < 256; i++) fetch("R3 bottom sweep", 16'(2 * i));

    // R7: odd addresses
    fetch("R7 odd FE01", 16'hFE01);
    check("R7 flag", {15'd0, mis_a}, 16'h0001);
    fetch("R7 odd FFFF", 16'hFFFF);
    fetch("R7 odd 01FF", 16'h01FF);
    fetch("R7 odd miss 1235", 16'h1235);

    // R8: aliasing off, single upper-bit differences miss
    fetch("R8 7E00", 16'h7E00);
    fetch("R8 FC00", 16'hFC00);
    fetch("R8 FDFE", 16'hFDFE);

    // R9: aliased bits ignored, unmasked bit still decoded
    fetch("R9 4000", 16'h4000);
    check("R9 4000 hit", {15'd0, be_b}, 16'h0000);
    fetch("R9 C1FE", 16'hC1FE);
    fetch("R9 8002", 16'h8002);
    fetch("R9 2000", 16'h2000);
    check("R9 2000 miss", {15'd0, be_b}, 16'h0001);

    // R2: output holds until the next edge after an address change
    fetch("R2 pre", 16'hFE10);
    fetch_addr = 16'hFE20;
    #1;
    check("R2 hold", instr_a, exp_word(16'hFE10));
    @(negedge clk);
    check("R2 update", instr_a, exp_word(16'hFE20));

    // Seeded random addresses against the model
    for (int n = 0; n < 400; n++) fetch("R2 random", 16'($urandom));

    // R1: reset in mid-run
    rst = 1'b1;
    @(negedge clk);
    check("R1 rerst instr", instr_a, 16'h0000);
    check("R1 rerst alias", instr_b, 16'h0000);
    check("R1 rerst flags", {12'd0, mis_a, be_a, mis_b, be_b}, 16'h0000);
    rst = 1'b0;
    fetch("R4 after reset", 16'hFFFE);

    finish_run();
  end

endmodule